// File: doc/BRIEF.md
# Chained Interrupt Status Queue Controller

This block gathers interrupt events from a serial-bus terminal core into two pairs of status and mask registers. The second status register carries a live summary bit that reports unmasked activity in the first. The host sees a single interrupt line and reads both status words. It clears status bits by writing ones.

When the terminal runs as a remote terminal or bus monitor, each message that raises an unmasked event is also logged. The log is a circular queue of two-word entries. A two-bit filter picks whether messages flagged valid, messages flagged invalid, or both get logged. A RAM parity error writes its own entry, which carries the failing address. The queue raises its own interrupts when a write lands in the half-way slot and when a write lands in the last slot before the pointer wraps. Half-full events from the terminal's stacks and buffers, and four user interrupt bits set by the message sequencer, also land in the second status register.

Top module: `isq_irq_ctrl`

## Requirements
- R1: Each status bit is set by a one-cycle event pulse and stays set until the host writes a one to the matching clear bit. An event arriving in the same cycle as its clear leaves the bit set.
- R2: Bit 0 of status word 2 reads 1 exactly when some bit of status word 1 is set and its mask-1 bit is 1. It follows mask and status changes in the cycle after the register update.
- R3: `irq_o` is high when any bit of status word 2 (including bit 0) is set with its mask-2 bit at 1. Both mask registers reset to zero.
- R4: A message is logged when `log_mode_i` is 1, at least one of its event bits is unmasked, and the filter admits it. Filter bit 0 admits messages with `msg_vld_i`=1, and filter bit 1 admits messages with `msg_vld_i`=0.
- R5: A message entry's event word has bit 15 = 0, bit 14 = `msg_vld_i`, and bits 13:0 = the event bits ANDed with mask 1. Its parameter word is `msg_ptr_i`.
- R6: In status word 2, bits 4:1 record the four half-full events and bits 8:5 record the four user interrupt bits.
- R7: A parity error sets status-2 bit 11. When logging is enabled, it writes an entry with event word 0x8000 and the parity address as parameter. It takes the queue in place of a message entry in the same cycle, and that message's status bits are still set.
- R8: `q_ev_o`/`q_par_o` show the oldest entry. `q_rd_i` removes it when the queue is not empty, and does nothing when it is empty. `q_count_o` gives the number of stored entries.
- R9: Status-2 bit 10 is set by a write into slot QD/2-1, and bit 9 by a write into slot QD-1, where the pointer wraps. The write pointer starts at slot 0 after reset.
- R10: A write to a full queue drops the oldest entry, and the count stays at QD.
- R11: After reset both status words read 0, `irq_o` is 0, and the queue is empty with count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| log_mode_i | input | 1 | Terminal/monitor mode: enables queue logging |
| filt_sel_i | input | 2 | Bit 0 admits valid messages, bit 1 admits invalid messages |
| evt1_i | input | S1W (14) | Message event pulses for status word 1 |
| msg_vld_i | input | 1 | Valid flag of the current message |
| msg_ptr_i | input | PW (16) | Message pointer logged as parameter word |
| par_err_i | input | 1 | RAM parity error pulse |
| par_addr_i | input | PW (16) | Address that failed parity |
| half_i | input | 4 | Half-full rollover event pulses |
| user_i | input | 4 | User interrupt set pulses from the sequencer |
| mask1_we_i | input | 1 | Write strobe for mask 1 |
| mask1_wd_i | input | S1W (14) | Mask 1 write data |
| mask2_we_i | input | 1 | Write strobe for mask 2 |
| mask2_wd_i | input | 12 | Mask 2 write data |
| clr1_i | input | S1W (14) | Write-one-to-clear for status word 1 |
| clr2_i | input | 12 | Write-one-to-clear for status word 2 |
| q_rd_i | input | 1 | Remove the oldest queue entry |
| irq_o | output | 1 | Host interrupt request |
| stat1_o | output | S1W (14) | Status word 1 |
| stat2_o | output | 12 | Status word 2 with chain bit 0 |
| q_ev_o | output | S1W+2 (16) | Event word of the oldest entry |
| q_par_o | output | PW (16) | Parameter word of the oldest entry |
| q_empty_o | output | 1 | Queue holds no entry |
| q_count_o | output | clog2(QD)+1 | Number of stored entries |

## Verification
A status bit that drops early or never sets shows on `stat1_o`/`stat2_o` at the next sampling point after the event or the clear. A wrong chain or mask state shows as a wrong bit 0 or a wrong `irq_o` in that same cycle. A broken filter or parity priority changes `q_count_o` and the head entry one cycle after the message. Pointer faults in the circular store take longer to appear. They show only when the half-way and wrap bits come on at the wrong write count, or when the head after an overflow is not the second-oldest entry.

// File: rtl/isq_pkg.sv
// Package: shared widths and status-word-2 bit positions for the
// interrupt status queue controller. Assumes a 12-bit status word 2.
package isq_pkg;
    localparam int S2W        = 12;
    localparam int N_HALF     = 4;
    localparam int N_USER     = 4;
    localparam int S2_CHAIN   = 0;
    localparam int S2_HALF_LO = 1;
    localparam int S2_USER_LO = S2_HALF_LO + N_HALF;
    localparam int S2_QROLL   = S2_USER_LO + N_USER;
    localparam int S2_QHALF   = S2_QROLL + 1;
    localparam int S2_PARERR  = S2_QHALF + 1;

    // Filter decision: bit 0 admits valid messages, bit 1 admits invalid ones.
    function automatic logic filter_pass(input logic vld, input logic [1:0] sel);
        return vld ? sel[0] : sel[1];
    endfunction
endpackage

// File: rtl/isq_stat_reg.sv
// Sticky status register with its mask register.
// Set pulses win over write-one-to-clear in the same cycle.
// pend_o is the OR of the set and enabled bits. Assumes single-cycle set pulses.
module isq_stat_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_wd_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);
    logic [W-1:0] stat_q;
    logic [W-1:0] mask_q;

    // Status bits: clear by write-one, set by event, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | set_i;
    end

    // Mask register: loaded by host write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_wd_i;
    end

    // Pending summary of enabled status bits.
    always_comb pend_o = |(stat_q & mask_q);

    assign stat_o = stat_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/isq_filter.sv
// Decides whether this cycle produces a queue entry and builds it.
// Parity-error entries take priority over message entries.
// Purely combinational; assumes events are one-cycle pulses.
module isq_filter #(
    parameter int S1W = 14,
    parameter int PW  = 16,
    localparam int EW = S1W + 2
) (
    input  logic           log_mode_i,
    input  logic [1:0]     filt_sel_i,
    input  logic [S1W-1:0] evt_i,
    input  logic [S1W-1:0] mask_i,
    input  logic           vld_i,
    input  logic [PW-1:0]  ptr_i,
    input  logic           par_err_i,
    input  logic [PW-1:0]  par_addr_i,
    output logic           wr_o,
    output logic [EW-1:0]  ev_word_o,
    output logic [PW-1:0]  par_word_o
);
    import isq_pkg::*;

    logic [S1W-1:0] hit;
    logic           msg_ok;
    logic           par_ok;

    // Entry selection and formatting.
    always_comb begin
        hit    = evt_i & mask_i;
        msg_ok = log_mode_i & (|hit) & filter_pass(vld_i, filt_sel_i);
        par_ok = log_mode_i & par_err_i;
        if (par_ok) begin
            ev_word_o  = {1'b1, 1'b0, {S1W{1'b0}}};
            par_word_o = par_addr_i;
        end else begin
            ev_word_o  = {1'b0, vld_i, hit};
            par_word_o = ptr_i;
        end
        wr_o = par_ok | msg_ok;
    end
endmodule

// File: rtl/isq_ring.sv
// Circular entry store. Overwrites the oldest entry when full, and
// pulses half_o / wrap_o on writes into the middle and last slots.
// Assumes DEPTH is a power of two of at least 2.
module isq_ring #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wd_i,
    input  logic          rd_i,
    output logic [DW-1:0] head_o,
    output logic [CW-1:0] count_o,
    output logic          empty_o,
    output logic          half_o,
    output logic          wrap_o
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q;
    logic [AW-1:0] rp_q;
    logic [CW-1:0] cnt_q;
    logic          full;
    logic          do_pop;

    // Occupancy flags and accepted pop.
    always_comb begin
        full    = (cnt_q == CW'(DEPTH));
        empty_o = (cnt_q == '0);
        do_pop  = rd_i & ~empty_o;
        half_o  = wr_i & (wp_q == AW'(DEPTH / 2 - 1));
        wrap_o  = wr_i & (wp_q == AW'(DEPTH - 1));
    end

    // Entry storage write.
    always_ff @(posedge clk) begin
        if (wr_i) mem[wp_q] <= wd_i;
    end

    // Pointer and count update; a full write pushes the read pointer on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_i) wp_q <= wp_q + 1'b1;
            if (do_pop || (wr_i && full)) rp_q <= rp_q + 1'b1;
            if (wr_i && !full && !do_pop) cnt_q <= cnt_q + 1'b1;
            else if (!wr_i && do_pop)     cnt_q <= cnt_q - 1'b1;
        end
    end

    assign head_o  = mem[rp_q];
    assign count_o = cnt_q;
endmodule

// File: rtl/isq_irq_ctrl.sv
// Top: two chained status/mask pairs plus the filtered interrupt log.
// Status word 2 bit 0 is a live summary of enabled status-1 bits.
// Assumes all event inputs are single-cycle pulses.
module isq_irq_ctrl #(
    parameter int S1W = 14,
    parameter int PW  = 16,
    parameter int QD  = 16,
    localparam int CW = $clog2(QD) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  log_mode_i,
    input  logic [1:0]            filt_sel_i,
    input  logic [S1W-1:0]        evt1_i,
    input  logic                  msg_vld_i,
    input  logic [PW-1:0]         msg_ptr_i,
    input  logic                  par_err_i,
    input  logic [PW-1:0]         par_addr_i,
    input  logic [3:0]            half_i,
    input  logic [3:0]            user_i,
    input  logic                  mask1_we_i,
    input  logic [S1W-1:0]        mask1_wd_i,
    input  logic                  mask2_we_i,
    input  logic [11:0]           mask2_wd_i,
    input  logic [S1W-1:0]        clr1_i,
    input  logic [11:0]           clr2_i,
    input  logic                  q_rd_i,
    output logic                  irq_o,
    output logic [S1W-1:0]        stat1_o,
    output logic [11:0]           stat2_o,
    output logic [S1W+1:0]        q_ev_o,
    output logic [PW-1:0]         q_par_o,
    output logic                  q_empty_o,
    output logic [CW-1:0]         q_count_o
);
    import isq_pkg::*;

    localparam int EW = S1W + 2;
    localparam int DW = EW + PW;

    logic [S1W-1:0] mask1;
    logic           pend1;
    logic [S2W-1:0] set2;
    logic [S2W-1:0] stat2_q;
    logic [S2W-1:0] mask2;
    logic           pend2;
    logic           q_wr;
    logic [EW-1:0]  q_ev_w;
    logic [PW-1:0]  q_par_w;
    logic [DW-1:0]  head;
    logic           q_half;
    logic           q_wrap;

    isq_stat_reg #(.W(S1W)) u_stat1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we_i (mask1_we_i),
        .mask_wd_i (mask1_wd_i),
        .set_i     (evt1_i),
        .clr_i     (clr1_i),
        .stat_o    (stat1_o),
        .mask_o    (mask1),
        .pend_o    (pend1)
    );

    // Status word 2 set sources; bit 0 is never stored.
    always_comb begin
        set2                                = '0;
        set2[S2_HALF_LO +: N_HALF]          = half_i;
        set2[S2_USER_LO +: N_USER]          = user_i;
        set2[S2_QROLL]                      = q_wrap;
        set2[S2_QHALF]                      = q_half;
        set2[S2_PARERR]                     = par_err_i;
    end

    isq_stat_reg #(.W(S2W)) u_stat2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we_i (mask2_we_i),
        .mask_wd_i (mask2_wd_i),
        .set_i     (set2),
        .clr_i     (clr2_i),
        .stat_o    (stat2_q),
        .mask_o    (mask2),
        .pend_o    (pend2)
    );

    isq_filter #(.S1W(S1W), .PW(PW)) u_filt (
        .log_mode_i (log_mode_i),
        .filt_sel_i (filt_sel_i),
        .evt_i      (evt1_i),
        .mask_i     (mask1),
        .vld_i      (msg_vld_i),
        .ptr_i      (msg_ptr_i),
        .par_err_i  (par_err_i),
        .par_addr_i (par_addr_i),
        .wr_o       (q_wr),
        .ev_word_o  (q_ev_w),
        .par_word_o (q_par_w)
    );

    isq_ring #(.DEPTH(QD), .DW(DW)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (q_wr),
        .wd_i    ({q_ev_w, q_par_w}),
        .rd_i    (q_rd_i),
        .head_o  (head),
        .count_o (q_count_o),
        .empty_o (q_empty_o),
        .half_o  (q_half),
        .wrap_o  (q_wrap)
    );

    // Chain bit insertion and host interrupt.
    always_comb begin
        stat2_o           = stat2_q;
        stat2_o[S2_CHAIN] = pend1;
        irq_o             = pend2 | (pend1 & mask2[S2_CHAIN]);
        q_ev_o            = head[PW +: EW];
        q_par_o           = head[PW-1:0];
    end
endmodule

// File: rtl/isq_irq_ctrl_chk.sv
// Checker for isq_irq_ctrl: temporal properties on ports, bound below.
module isq_irq_ctrl_chk #(
    parameter int S1W = 14,
    parameter int QD  = 16,
    localparam int CW = $clog2(QD) + 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [S1W-1:0] evt1_i,
    input logic [S1W-1:0] clr1_i,
    input logic           log_mode_i,
    input logic           q_rd_i,
    input logic           irq_o,
    input logic [S1W-1:0] stat1_o,
    input logic [11:0]    stat2_o,
    input logic           q_empty_o,
    input logic [CW-1:0]  q_count_o
);
    // R1: set bits persist unless cleared
    a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat1_o) & ~$past(clr1_i)) & ~stat1_o) == '0));
    // R1: every event pulse leaves its bit set
    a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt1_i) |=> (($past(evt1_i) & ~stat1_o) == '0));
    // R2: no chain bit without any status-1 bit
    a_r2_chain_needs_stat1: assert property (@(posedge clk) disable iff (!rst_n)
        (stat1_o == '0) |-> !stat2_o[0]);
    // R3: interrupt needs a status-2 bit
    a_r3_irq_needs_stat: assert property (@(posedge clk) disable iff (!rst_n)
        (stat2_o == '0) |-> !irq_o);
    // R4: no logging outside terminal/monitor mode
    a_r4_no_log_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!log_mode_i && !q_rd_i) |=> (q_count_o == $past(q_count_o)));
    // R8: pop on empty queue is ignored
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty_o && q_rd_i && !log_mode_i) |=> q_empty_o);
    // R10: count never exceeds depth
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q_count_o <= CW'(QD));
endmodule

bind isq_irq_ctrl isq_irq_ctrl_chk #(.S1W(S1W), .QD(QD)) u_isq_chk (.*);

// File: tb/test_isq_irq_ctrl.sv
module test_isq_irq_ctrl;
    localparam int S1W = 14;
    localparam int PW  = 16;
    localparam int QD  = 16;
    localparam int CW  = $clog2(QD) + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           log_mode_i = 1'b0;
    logic [1:0]     filt_sel_i = 2'b00;
    logic [S1W-1:0] evt1_i = '0;
    logic           msg_vld_i = 1'b0;
    logic [PW-1:0]  msg_ptr_i = '0;
    logic           par_err_i = 1'b0;
    logic [PW-1:0]  par_addr_i = '0;
    logic [3:0]     half_i = '0;
    logic [3:0]     user_i = '0;
    logic           mask1_we_i = 1'b0;
    logic [S1W-1:0] mask1_wd_i = '0;
    logic           mask2_we_i = 1'b0;
    logic [11:0]    mask2_wd_i = '0;
    logic [S1W-1:0] clr1_i = '0;
    logic [11:0]    clr2_i = '0;
    logic           q_rd_i = 1'b0;
    logic           irq_o;
    logic [S1W-1:0] stat1_o;
    logic [11:0]    stat2_o;
    logic [S1W+1:0] q_ev_o;
    logic [PW-1:0]  q_par_o;
    logic           q_empty_o;
    logic [CW-1:0]  q_count_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    isq_irq_ctrl i_isq_irq_ctrl (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic set_mask1(input logic [S1W-1:0] m);
        mask1_we_i = 1'b1; mask1_wd_i = m; tick(); mask1_we_i = 1'b0;
    endtask

    task automatic set_mask2(input logic [11:0] m);
        mask2_we_i = 1'b1; mask2_wd_i = m; tick(); mask2_we_i = 1'b0;
    endtask

    // {evt[13:0], vld, filt[1:0], mode, logged}
    localparam logic [18:0] VEC [9] = '{
        {14'h0001, 1'b1, 2'b01, 1'b1, 1'b1},
        {14'h0002, 1'b0, 2'b01, 1'b1, 1'b0},
        {14'h0004, 1'b0, 2'b10, 1'b1, 1'b1},
        {14'h0008, 1'b1, 2'b10, 1'b1, 1'b0},
        {14'h0010, 1'b1, 2'b11, 1'b1, 1'b1},
        {14'h0020, 1'b0, 2'b11, 1'b0, 1'b0},
        {14'h2000, 1'b1, 2'b11, 1'b1, 1'b0},
        {14'h2041, 1'b0, 2'b11, 1'b1, 1'b1},
        {14'h0000, 1'b1, 2'b11, 1'b1, 1'b0}
    };

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11 reset state
        chk("R11 stat1", 32'(stat1_o), 32'h0);
        chk("R11 stat2", 32'(stat2_o), 32'h0);
        chk("R11 irq", 32'(irq_o), 32'h0);
        chk("R11 empty", 32'(q_empty_o), 32'h1);
        chk("R11 count", 32'(q_count_o), 32'h0);

        set_mask1(14'h1FFF);
        // R4 R5 filter vectors
        for (int i = 0; i < 9; i++) begin
            logic [S1W-1:0] ev;
            logic vl, lg;
            ev = VEC[i][18:5]; vl = VEC[i][4]; lg = VEC[i][0];
            evt1_i = ev; msg_vld_i = vl; filt_sel_i = VEC[i][3:2];
            log_mode_i = VEC[i][1]; msg_ptr_i = 16'hA000 + 16'(i);
            tick();
            evt1_i = '0; log_mode_i = 1'b0;
            chk("R4 logged", 32'(q_count_o), 32'(lg));
            chk("R1 stat1 set", 32'(stat1_o), 32'(ev));
            if (lg) begin
                chk("R5 event word", 32'(q_ev_o), 32'({1'b0, vl, ev & 14'h1FFF}));
                chk("R5 param word", 32'(q_par_o), 32'h0000A000 + i);
            end
            clr1_i = '1; q_rd_i = lg; tick(); clr1_i = '0; q_rd_i = 1'b0;
        end
        chk("R1 cleared", 32'(stat1_o), 32'h0);

        // R2 R3 chain
        evt1_i = 14'h2000; tick(); evt1_i = '0;
        chk("R2 masked no chain", 32'(stat2_o[0]), 32'h0);
        chk("R3 no irq", 32'(irq_o), 32'h0);
        set_mask1(14'h3FFF);
        chk("R2 chain on", 32'(stat2_o[0]), 32'h1);
        chk("R3 chain masked", 32'(irq_o), 32'h0);
        set_mask2(12'h001);
        chk("R3 irq via chain", 32'(irq_o), 32'h1);
        clr1_i = '1; tick(); clr1_i = '0;
        chk("R2 chain off", 32'(stat2_o[0]), 32'h0);
        chk("R3 irq off", 32'(irq_o), 32'h0);

        // R6 half-full and user bits, R1 set beats clear
        half_i = 4'b0101; user_i = 4'b1000; tick(); half_i = '0; user_i = '0;
        chk("R6 stat2", 32'(stat2_o), 32'h10A);
        set_mask2(12'h100);
        chk("R3 irq user", 32'(irq_o), 32'h1);
        clr2_i = 12'h10A; user_i = 4'b1000; tick(); clr2_i = '0; user_i = '0;
        chk("R1 set over clear", 32'(stat2_o), 32'h100);
        clr2_i = 12'hFFF; tick(); clr2_i = '0;
        chk("R1 stat2 clear", 32'(stat2_o), 32'h0);
        chk("R3 irq drop", 32'(irq_o), 32'h0);

        // R7 parity precedence
        log_mode_i = 1'b1; filt_sel_i = 2'b11; evt1_i = 14'h0001; msg_vld_i = 1'b1;
        msg_ptr_i = 16'h5555; par_err_i = 1'b1; par_addr_i = 16'h1234;
        tick();
        log_mode_i = 1'b0; evt1_i = '0; par_err_i = 1'b0;
        chk("R7 one entry", 32'(q_count_o), 32'h1);
        chk("R7 event word", 32'(q_ev_o), 32'h8000);
        chk("R7 address", 32'(q_par_o), 32'h1234);
        chk("R7 stat2 bit11", 32'(stat2_o[11]), 32'h1);
        chk("R7 msg stat1", 32'(stat1_o), 32'h1);
        q_rd_i = 1'b1; tick();
        // R8 pop on empty ignored
        tick(); q_rd_i = 1'b0;
        chk("R8 empty after pops", 32'(q_empty_o), 32'h1);
        chk("R8 count zero", 32'(q_count_o), 32'h0);

        // R9 R10 ring from a fresh pointer
        do_reset();
        set_mask1(14'h3FFF);
        log_mode_i = 1'b1; filt_sel_i = 2'b11; msg_vld_i = 1'b1;
        for (int k = 0; k < QD; k++) begin
            evt1_i = 14'h0001; msg_ptr_i = 16'h0100 + 16'(k);
            tick();
            chk("R9 half bit", 32'(stat2_o[10]), 32'(k >= QD / 2 - 1));
            chk("R9 wrap bit", 32'(stat2_o[9]), 32'(k == QD - 1));
            chk("R8 count", 32'(q_count_o), 32'(k + 1));
        end
        msg_ptr_i = 16'h0110; tick();
        evt1_i = '0; log_mode_i = 1'b0;
        chk("R10 count full", 32'(q_count_o), 32'(QD));
        chk("R10 oldest dropped", 32'(q_par_o), 32'h0101);
        q_rd_i = 1'b1; tick(); q_rd_i = 1'b0;
        chk("R8 head after pop", 32'(q_par_o), 32'h0102);
        chk("R8 count after pop", 32'(q_count_o), 32'(QD - 1));

        // R11 reset clears live state
        do_reset();
        chk("R11 stat2 after reset", 32'(stat2_o), 32'h0);
        chk("R11 empty after reset", 32'(q_empty_o), 32'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule